// File: doc/BRIEF.md
# Segment Protection and Limit Checker

This block decides, for one memory access at a time, whether a segmented access in 32-bit-style protected operation must raise a general-protection fault. Each access presents a segment code, the segment's selector, its attribute bits (readable, writable, expand-down), its base and limit, the virtual address, the access size in bytes, the access kind, a store-check flag and the address-size selection. The block applies three rules: the null-selector rule, the read/write permission rule and the limit rule. It reports a single fault flag together with the segment offset, truncated to the active address width.

The block is one pipeline stage. All rules are evaluated combinationally from the inputs, and the results are captured on the clock edge that accepts a valid access. A two-state controller tracks whether a result is on the outputs. In state GS_IDLE nothing is reported. In state GS_REPORT the outputs carry the result of the access accepted on the previous edge. The transition GS_IDLE→GS_REPORT and the transition GS_REPORT→GS_REPORT (back-to-back traffic) are taken when `in_valid` is high. The transitions GS_REPORT→GS_IDLE and GS_IDLE→GS_IDLE are taken when it is low.

Top module: `seg_guard`

## Requirements
- R1: A zero selector raises a fault, unless the segment code is 6 (scratch helper), 8 (task state), 9 (interrupt table) or 10 (linear helper). These four codes are exempt from the null rule.
- R2: For segment codes 0 to 6 (data/code class), a fault is raised in three cases: a write (`acc_kind`=1) to a segment without the writable bit; any access with `store_chk`=1 to a segment without the writable bit; a read (`acc_kind`=0) of a segment without the readable bit. A fetch (`acc_kind`=2 or 3) is never refused by permission bits.
- R3: The address width is 8·2^n bits. n is `alt_asz` when `size_ovr`=1 and `def_asz` otherwise. Widths at or above VA_W use all VA_W bits.
- R4: `seg_off` is (vaddr − seg_base) modulo 2^width. The end offset is `seg_off` + `acc_size` − 1, computed without truncation.
- R5: For a segment without expand-down, a fault is raised when either the offset or the end offset is greater than `seg_limit`.
- R6: For a data/code-class segment with the expand-down bit set, a fault is raised when either the offset or the end offset is less than or equal to `seg_limit`.
- R7: Segment codes 7 to 15 (system class) ignore the readable, writable and expand-down bits and always use the limit check of R5.
- R8: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. `gp_fault` and `seg_off` in that cycle belong to that access.
- R9: While `out_valid` is low, `gp_fault` and `seg_off` are zero, whatever the inputs were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An access is presented this cycle |
| seg_code | input | 4 | Segment code (0–6 data/code, 7–15 system) |
| seg_sel | input | 16 | Segment selector value |
| attr_rd | input | 1 | Segment readable |
| attr_wr | input | 1 | Segment writable |
| attr_xdn | input | 1 | Segment expands downward |
| seg_base | input | VA_W | Segment base address |
| seg_limit | input | VA_W | Segment limit |
| vaddr | input | VA_W | Virtual address of the access |
| acc_size | input | SIZE_W | Access size in bytes, nonzero |
| acc_kind | input | 2 | 0 read, 1 write, 2/3 fetch |
| store_chk | input | 1 | Check as if the access were a store |
| size_ovr | input | 1 | Use the alternate address size |
| def_asz | input | 2 | Default address-size exponent n |
| alt_asz | input | 2 | Alternate address-size exponent n |
| out_valid | output | 1 | Result valid |
| gp_fault | output | 1 | General-protection fault |
| seg_off | output | VA_W | Truncated segment offset |

## Verification
Every result is due in the cycle right after the cycle that presents the access. The driver applies inputs on the falling edge and records the expected fault and offset in a queue. The monitor samples on the following falling edge, which is one rising edge later, and compares whenever `out_valid` is high. A cycle with `in_valid` low but faulting inputs is checked on its own falling edge one cycle later, to confirm the outputs stay zero. At the end the queue must be empty, so no result was lost or delayed.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;
    localparam int SEG_W = 4;
    localparam logic [SEG_W-1:0] SEG_SCRATCH = 4'd6;
    localparam logic [SEG_W-1:0] SEG_TASK    = 4'd8;
    localparam logic [SEG_W-1:0] SEG_INTTAB  = 4'd9;
    localparam logic [SEG_W-1:0] SEG_LINEAR  = 4'd10;

    localparam logic [1:0] ACC_READ  = 2'd0;
    localparam logic [1:0] ACC_WRITE = 2'd1;

    typedef enum logic {GS_IDLE, GS_REPORT} guard_state_t;

    function automatic logic seg_is_data(input logic [SEG_W-1:0] code);
        return code <= SEG_SCRATCH;
    endfunction

    function automatic logic seg_null_exempt(input logic [SEG_W-1:0] code);
        return (code == SEG_SCRATCH) || (code == SEG_TASK) ||
               (code == SEG_INTTAB)  || (code == SEG_LINEAR);
    endfunction
endpackage

// File: rtl/seg_offset_calc.sv
module seg_offset_calc #(
    parameter int VA_W   = 32,
    parameter int SIZE_W = 4
) (
    input  logic [VA_W-1:0]   vaddr,
    input  logic [VA_W-1:0]   seg_base,
    input  logic [SIZE_W-1:0] acc_size,
    input  logic              size_ovr,
    input  logic [1:0]        def_asz,
    input  logic [1:0]        alt_asz,
    output logic [VA_W-1:0]   offset,
    output logic [VA_W:0]     end_off
);
    localparam int EW = VA_W + 1;

    logic [1:0]      width_exp;
    logic [VA_W-1:0] width_mask;
    int              width_bits;

    always_comb begin
        width_exp  = size_ovr ? alt_asz : def_asz;
        width_bits = 8 << width_exp;
        width_mask = '1;
        for (int i = 0; i < VA_W; i++) begin
            if (i >= width_bits) width_mask[i] = 1'b0;
        end
        offset  = (vaddr - seg_base) & width_mask;
        end_off = EW'({1'b0, offset}) + EW'(acc_size) - EW'(1);
    end
endmodule

// File: rtl/seg_rule_check.sv
module seg_rule_check
    import seg_guard_pkg::*;
(
    input  logic [SEG_W-1:0] seg_code,
    input  logic [15:0]      seg_sel,
    input  logic             attr_rd,
    input  logic             attr_wr,
    input  logic             attr_xdn,
    input  logic [1:0]       acc_kind,
    input  logic             store_chk,
    output logic             null_fault,
    output logic             perm_fault,
    output logic             use_xdn
);
    logic data_class;

    always_comb begin
        data_class = seg_is_data(seg_code);
        null_fault = (seg_sel == 16'h0) && !seg_null_exempt(seg_code);
        perm_fault = data_class &&
                     ((!attr_wr && ((acc_kind == ACC_WRITE) || store_chk)) ||
                      (!attr_rd && (acc_kind == ACC_READ)));
        use_xdn    = data_class && attr_xdn;
    end
endmodule

// File: rtl/seg_limit_cmp.sv
module seg_limit_cmp #(
    parameter int VA_W = 32
) (
    input  logic [VA_W-1:0] offset,
    input  logic [VA_W:0]   end_off,
    input  logic [VA_W-1:0] seg_limit,
    input  logic            use_xdn,
    output logic            limit_fault
);
    logic [VA_W:0] lim_ext;
    logic [VA_W:0] off_ext;

    always_comb begin
        lim_ext = {1'b0, seg_limit};
        off_ext = {1'b0, offset};
        if (use_xdn)
            limit_fault = (off_ext <= lim_ext) || (end_off <= lim_ext);
        else
            limit_fault = (off_ext > lim_ext) || (end_off > lim_ext);
    end
endmodule

// File: rtl/seg_guard.sv
module seg_guard
    import seg_guard_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int SIZE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        seg_code,
    input  logic [15:0]       seg_sel,
    input  logic              attr_rd,
    input  logic              attr_wr,
    input  logic              attr_xdn,
    input  logic [VA_W-1:0]   seg_base,
    input  logic [VA_W-1:0]   seg_limit,
    input  logic [VA_W-1:0]   vaddr,
    input  logic [SIZE_W-1:0] acc_size,
    input  logic [1:0]        acc_kind,
    input  logic              store_chk,
    input  logic              size_ovr,
    input  logic [1:0]        def_asz,
    input  logic [1:0]        alt_asz,
    output logic              out_valid,
    output logic              gp_fault,
    output logic [VA_W-1:0]   seg_off
);
    guard_state_t    state_q, state_d;
    logic [VA_W-1:0] offset;
    logic [VA_W:0]   end_off;
    logic            null_fault, perm_fault, use_xdn, limit_fault;

    seg_offset_calc #(.VA_W(VA_W), .SIZE_W(SIZE_W)) u_offset (
        .vaddr(vaddr), .seg_base(seg_base), .acc_size(acc_size),
        .size_ovr(size_ovr), .def_asz(def_asz), .alt_asz(alt_asz),
        .offset(offset), .end_off(end_off)
    );

    seg_rule_check u_rules (
        .seg_code(seg_code), .seg_sel(seg_sel), .attr_rd(attr_rd),
        .attr_wr(attr_wr), .attr_xdn(attr_xdn), .acc_kind(acc_kind),
        .store_chk(store_chk), .null_fault(null_fault),
        .perm_fault(perm_fault), .use_xdn(use_xdn)
    );

    seg_limit_cmp #(.VA_W(VA_W)) u_limit (
        .offset(offset), .end_off(end_off), .seg_limit(seg_limit),
        .use_xdn(use_xdn), .limit_fault(limit_fault)
    );

    always_comb begin
        unique case (state_q)
            GS_IDLE:   state_d = in_valid ? GS_REPORT : GS_IDLE;
            GS_REPORT: state_d = in_valid ? GS_REPORT : GS_IDLE;
            default:   state_d = GS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gp_fault <= 1'b0;
            seg_off  <= '0;
        end else if (in_valid) begin
            gp_fault <= null_fault | perm_fault | limit_fault;
            seg_off  <= offset;
        end else begin
            gp_fault <= 1'b0;
            seg_off  <= '0;
        end
    end

    assign out_valid = (state_q == GS_REPORT);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R8
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!gp_fault && seg_off == '0)); // R9
    AST_NULL_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && seg_sel == 16'h0 && !seg_null_exempt(seg_code)) |=> gp_fault); // R1
    AST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && seg_code <= 4'd6 && !attr_wr && acc_kind == 2'd1) |=> gp_fault); // R2

    generate
        if (VA_W > 16) begin : g_width_chk
            AST_WIDTH16: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !size_ovr && def_asz == 2'd1) |=> (seg_off[VA_W-1:16] == '0)); // R3
        end
    endgenerate
endmodule

// File: tb/test_seg_guard.sv
module test_seg_guard;
    localparam int VA_W   = 32;
    localparam int SIZE_W = 4;

    typedef struct {
        bit              fault;
        bit [VA_W-1:0]   off;
        string           req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [3:0]        seg_code = '0;
    logic [15:0]       seg_sel = '0;
    logic              attr_rd = 1'b0, attr_wr = 1'b0, attr_xdn = 1'b0;
    logic [VA_W-1:0]   seg_base = '0, seg_limit = '0, vaddr = '0;
    logic [SIZE_W-1:0] acc_size = '0;
    logic [1:0]        acc_kind = '0;
    logic              store_chk = 1'b0, size_ovr = 1'b0;
    logic [1:0]        def_asz = 2'd2, alt_asz = 2'd2;
    logic              out_valid, gp_fault;
    logic [VA_W-1:0]   seg_off;

    exp_t sb_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    always #2 clk = ~clk;

    seg_guard #(.VA_W(VA_W), .SIZE_W(SIZE_W)) i_seg_guard (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .seg_code(seg_code),
        .seg_sel(seg_sel), .attr_rd(attr_rd), .attr_wr(attr_wr),
        .attr_xdn(attr_xdn), .seg_base(seg_base), .seg_limit(seg_limit),
        .vaddr(vaddr), .acc_size(acc_size), .acc_kind(acc_kind),
        .store_chk(store_chk), .size_ovr(size_ovr), .def_asz(def_asz),
        .alt_asz(alt_asz), .out_valid(out_valid), .gp_fault(gp_fault),
        .seg_off(seg_off)
    );

    function automatic bit [VA_W-1:0] model_off(bit [VA_W-1:0] va, bit [VA_W-1:0] base,
                                                bit ovr, bit [1:0] dn, bit [1:0] an);
        int w = 8 << (ovr ? an : dn);
        bit [VA_W-1:0] d = va - base;
        if (w < VA_W) d = d & ((VA_W'(1) << w) - 1);
        return d;
    endfunction

    function automatic bit model_fault(bit [3:0] code, bit [15:0] sel, bit rd, bit wr,
                                       bit xdn, bit [VA_W-1:0] off, bit [VA_W-1:0] lim,
                                       int sz, bit [1:0] kind, bit sc);
        bit  data   = (code <= 4'd6);
        bit  exempt = (code == 4'd6) || (code == 4'd8) || (code == 4'd9) || (code == 4'd10);
        longint o   = longint'(off);
        longint e   = o + sz - 1;
        longint l   = longint'(lim);
        bit  f      = 1'b0;
        if (sel == 0 && !exempt) f = 1'b1;
        if (data && !wr && (kind == 2'd1 || sc)) f = 1'b1;
        if (data && !rd && kind == 2'd0) f = 1'b1;
        if (data && xdn) begin
            if (o <= l || e <= l) f = 1'b1;
        end else begin
            if (o > l || e > l) f = 1'b1;
        end
        return f;
    endfunction

    task automatic drive(input string req, input bit [3:0] code, input bit [15:0] sel,
                         input bit rd, input bit wr, input bit xdn,
                         input bit [VA_W-1:0] base, input bit [VA_W-1:0] lim,
                         input bit [VA_W-1:0] va, input int sz, input bit [1:0] kind,
                         input bit sc, input bit ovr, input bit [1:0] dn, input bit [1:0] an);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; seg_code = code; seg_sel = sel; attr_rd = rd; attr_wr = wr;
        attr_xdn = xdn; seg_base = base; seg_limit = lim; vaddr = va;
        acc_size = SIZE_W'(sz); acc_kind = kind; store_chk = sc; size_ovr = ovr;
        def_asz = dn; alt_asz = an;
        e.off   = model_off(va, base, ovr, dn, an);
        e.fault = model_fault(code, sel, rd, wr, xdn, e.off, lim, sz, kind, sc);
        e.req   = req;
        sb_q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            exp_t e;
            n_checks++;
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL R8: result with nothing pending, actual out_valid=1 expected 0");
            end else begin
                e = sb_q.pop_front();
                if (gp_fault !== e.fault || seg_off !== e.off) begin
                    n_fail++;
                    $display("FAIL %s: actual fault=%0b off=%h expected fault=%0b off=%h",
                             e.req, gp_fault, seg_off, e.fault, e.off);
                end
            end
        end
    end

    task automatic check(input string req, input bit ok, input string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R8: watchdog expired, actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9", out_valid === 1'b0 && gp_fault === 1'b0 && seg_off === '0,
              $sformatf("reset actual v=%0b f=%0b off=%h expected 0 0 0", out_valid, gp_fault, seg_off));
        rst_n = 1'b1;
        // R5 normal limit checks
        drive("R5", 4'd3, 16'h10, 1, 1, 0, 32'h1000, 32'hFF, 32'h1010, 4, 2'd0, 0, 0, 2'd2, 2'd2);
        drive("R5", 4'd3, 16'h10, 1, 1, 0, 32'h1000, 32'hFF, 32'h10FC, 4, 2'd0, 0, 0, 2'd2, 2'd2);
        drive("R5", 4'd3, 16'h10, 1, 1, 0, 32'h1000, 32'hFF, 32'h10FD, 4, 2'd0, 0, 0, 2'd2, 2'd2);
        drive("R5", 4'd3, 16'h10, 1, 1, 0, 32'h1000, 32'hFF, 32'h1100, 1, 2'd0, 0, 0, 2'd2, 2'd2);
        // R1 null selector
        drive("R1", 4'd3, 16'h0, 1, 1, 0, 32'h0, 32'hFF, 32'h10, 1, 2'd0, 0, 0, 2'd2, 2'd2);
        drive("R1", 4'd8, 16'h0, 1, 1, 0, 32'h0, 32'hFF, 32'h10, 1, 2'd0, 0, 0, 2'd2, 2'd2);
        drive("R1", 4'd6, 16'h0, 1, 1, 0, 32'h0, 32'hFF, 32'h10, 1, 2'd0, 0, 0, 2'd2, 2'd2);
        drive("R1", 4'd11, 16'h0, 1, 1, 0, 32'h0, 32'hFF, 32'h10, 1, 2'd0, 0, 0, 2'd2, 2'd2);
        // R2 permissions
        drive("R2", 4'd2, 16'h8, 1, 0, 0, 32'h0, 32'hFF, 32'h10, 2, 2'd1, 0, 0, 2'd2, 2'd2);
        drive("R2", 4'd2, 16'h8, 1, 0, 0, 32'h0, 32'hFF, 32'h10, 2, 2'd0, 1, 0, 2'd2, 2'd2);
        drive("R2", 4'd2, 16'h8, 0, 1, 0, 32'h0, 32'hFF, 32'h10, 2, 2'd0, 0, 0, 2'd2, 2'd2);
        drive("R2", 4'd1, 16'h8, 0, 0, 0, 32'h0, 32'hFF, 32'h10, 2, 2'd2, 0, 0, 2'd2, 2'd2);
        drive("R2", 4'd2, 16'h8, 1, 1, 0, 32'h0, 32'hFF, 32'h10, 2, 2'd1, 1, 0, 2'd2, 2'd2);
        // R3 / R4 address width and wrap
        drive("R3", 4'd3, 16'h8, 1, 1, 0, 32'h0, 32'hFFFF, 32'h0001_0005, 1, 2'd0, 0, 0, 2'd1, 2'd2);
        drive("R3", 4'd3, 16'h8, 1, 1, 0, 32'h30, 32'hFF, 32'h1234, 1, 2'd0, 0, 1, 2'd2, 2'd0);
        drive("R4", 4'd3, 16'h8, 1, 1, 0, 32'h20, 32'hFFFF, 32'h10, 1, 2'd0, 0, 0, 2'd1, 2'd2);
        drive("R4", 4'd3, 16'h8, 1, 1, 0, 32'h20, 32'hFFFF, 32'h10, 8, 2'd0, 0, 0, 2'd1, 2'd2);
        // R6 expand-down
        drive("R6", 4'd3, 16'h8, 1, 1, 1, 32'h0, 32'hFF, 32'h100, 4, 2'd0, 0, 0, 2'd2, 2'd2);
        drive("R6", 4'd3, 16'h8, 1, 1, 1, 32'h0, 32'hFF, 32'hFE, 4, 2'd0, 0, 0, 2'd2, 2'd2);
        drive("R6", 4'd3, 16'h8, 1, 1, 1, 32'h0, 32'h100, 32'h100, 4, 2'd0, 0, 0, 2'd2, 2'd2);
        // R7 system class ignores attributes
        drive("R7", 4'd9, 16'h8, 0, 0, 1, 32'h0, 32'hFF, 32'h10, 4, 2'd1, 1, 0, 2'd2, 2'd2);
        drive("R7", 4'd9, 16'h8, 0, 0, 1, 32'h0, 32'hFF, 32'h100, 4, 2'd0, 0, 0, 2'd2, 2'd2);
        idle();
        // R9: faulting inputs with valid low leave the outputs quiet
        seg_sel = 16'h0; seg_code = 4'd3; vaddr = 32'hFFFF_0000; seg_limit = '0;
        @(negedge clk);
        check("R9", out_valid === 1'b0 && gp_fault === 1'b0 && seg_off === '0,
              $sformatf("idle actual v=%0b f=%0b off=%h expected 0 0 0", out_valid, gp_fault, seg_off));
        check("R8", sb_q.size() == 0,
              $sformatf("pending actual %0d expected 0", sb_q.size()));
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule